// File: doc/BRIEF.md
# Interrupt Selection and Delegation Unit

This block decides, in a single combinational pass, whether the hart should take an interrupt now. If it should, the block also reports which interrupt wins and the privilege level whose handler receives it. Its inputs are the pending vector, the enable vector, the machine and supervisor delegation masks, the current privilege, the machine and supervisor global enable bits, and two flags that say whether supervisor and user modes exist. Its outputs are a take strobe, a cause code and a target privilege.

The candidates are pending AND enabled. The machine delegation mask splits these candidates into a set the machine keeps and a set that is handed downward. Only when the machine's own set is empty or gated off is the handed-down set examined at supervisor level, where the supervisor delegation mask splits it again. Nothing is delegated further than supervisor. If supervisor mode or user mode is absent, delegation is bypassed entirely. A fixed nine-entry ranking then picks a single winner from the selected set.

Top module: `irq_dispatch`

## Requirements
- R1: The winner is the set bit of highest rank in the selected set. Ranked from highest, the bit positions are 11, 3, 7, 9, 1, 5, 8, 0, 4.
- R2: The candidate vector is pending AND enable. When it is zero, take_o is 0.
- R3: A candidate whose machine delegation bit is clear stays at machine level. A candidate whose bit is set is handed to supervisor level.
- R4: Privilege is encoded as 2'b00 user, 2'b01 supervisor, 2'b11 machine. Machine-level interrupts are enabled when cur_priv_i is below machine. In machine mode they are enabled only when m_gie_i is 1.
- R5: Supervisor-level interrupts are enabled in user mode, and in supervisor mode when s_gie_i is 1. They are never enabled in machine mode.
- R6: A non-empty, enabled machine-level set wins with target machine. Otherwise the handed-down set is split by the supervisor delegation mask, and the bits that stay are taken with target supervisor if supervisor level is enabled.
- R7: When sup_present_i or usr_present_i is 0, delegation and the global enables are ignored, and the winner of pending AND enable is taken with target machine.
- R8: cause_o equals the bit position of the winner: 11, 3, 7 for machine external/software/timer, 9, 1, 5 for supervisor, and 8, 0, 4 for user.
- R9: Candidates that the supervisor delegation mask also hands down are never taken.
- R10: Bit positions 2, 6, 10 and every position from 12 upward are never selected, even when pending and enabled.
- R11: When take_o is 0, cause_o and target_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irq_pend_i | input | W | Pending interrupt bits |
| irq_en_i | input | W | Per-interrupt enable bits |
| m_deleg_i | input | W | Machine delegation mask |
| s_deleg_i | input | W | Supervisor delegation mask |
| cur_priv_i | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| sup_present_i | input | 1 | Supervisor mode implemented |
| usr_present_i | input | 1 | User mode implemented |
| take_o | output | 1 | An interrupt is to be taken |
| cause_o | output | $clog2(W) | Cause code of the winner |
| target_o | output | 2 | Privilege that handles it |

## Verification
The assertions assume that cur_priv_i never carries the reserved code 2'b10. They also assume that in a machine-only configuration the privilege input is meaningful only as machine, so no check ties the target to the enable rules in that case. The stimulus never drives 2'b10: the sweep loops over the three legal privilege codes, all four global-enable combinations and all four presence combinations. For each setting it applies pseudo-random pending, enable and delegation vectors, with sparse enables so that the ranking and the fall-through to supervisor are both exercised. Directed cases cover each gating rule and the positions that can never win.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int PRIV_W = 2;
  localparam logic [PRIV_W-1:0] PRIV_U = 2'b00;
  localparam logic [PRIV_W-1:0] PRIV_S = 2'b01;
  localparam logic [PRIV_W-1:0] PRIV_M = 2'b11;
  localparam int RANK_NONE = 9;
  localparam int RANK_W    = 4;

  // rank of a bit position, 0 is most urgent, RANK_NONE means never selected
  function automatic logic [RANK_W-1:0] rank_of(input int pos);
    case (pos)
      11:      rank_of = 4'd0;
      3:       rank_of = 4'd1;
      7:       rank_of = 4'd2;
      9:       rank_of = 4'd3;
      1:       rank_of = 4'd4;
      5:       rank_of = 4'd5;
      8:       rank_of = 4'd6;
      0:       rank_of = 4'd7;
      4:       rank_of = 4'd8;
      default: rank_of = RANK_W'(RANK_NONE);
    endcase
  endfunction
endpackage

// File: rtl/irq_level_split.sv
module irq_level_split #(
  parameter int W = 16
) (
  input  logic [W-1:0] cand_i,
  input  logic [W-1:0] deleg_i,
  input  logic         lvl_en_i,
  output logic [W-1:0] keep_o,
  output logic [W-1:0] pass_o,
  output logic         take_o
);
  always_comb begin
    keep_o = cand_i & ~deleg_i;
    pass_o = cand_i & deleg_i;
    take_o = lvl_en_i && (keep_o != '0);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_dispatch_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          hit_o,
  output logic [CW-1:0] idx_o
);
  logic [RANK_W-1:0] best_rank;

  always_comb begin
    best_rank = RANK_W'(RANK_NONE);
    idx_o     = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i] && (rank_of(i) < best_rank)) begin
        best_rank = rank_of(i);
        idx_o     = CW'(i);
      end
    end
    hit_o = (best_rank != RANK_W'(RANK_NONE));
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int W = 16,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]      irq_pend_i,
  input  logic [W-1:0]      irq_en_i,
  input  logic [W-1:0]      m_deleg_i,
  input  logic [W-1:0]      s_deleg_i,
  input  logic [PRIV_W-1:0] cur_priv_i,
  input  logic              m_gie_i,
  input  logic              s_gie_i,
  input  logic              sup_present_i,
  input  logic              usr_present_i,
  output logic              take_o,
  output logic [CW-1:0]     cause_o,
  output logic [PRIV_W-1:0] target_o
);
  logic [W-1:0]      cand;
  logic              m_lvl_en, s_lvl_en, flat_cfg;
  logic [W-1:0]      m_keep, m_pass, s_keep, s_pass;
  logic              m_take, s_take;
  logic [W-1:0]      sel_vec;
  logic [PRIV_W-1:0] sel_tgt;
  logic              pick_hit;
  logic [CW-1:0]     pick_idx;

  always_comb begin
    cand     = irq_pend_i & irq_en_i;
    flat_cfg = !sup_present_i || !usr_present_i;
    m_lvl_en = (cur_priv_i != PRIV_M) || m_gie_i;
    s_lvl_en = sup_present_i &&
               ((cur_priv_i == PRIV_U) || ((cur_priv_i == PRIV_S) && s_gie_i));
  end

  irq_level_split #(.W(W)) u_m_lvl (
    .cand_i  (cand),
    .deleg_i (m_deleg_i),
    .lvl_en_i(m_lvl_en),
    .keep_o  (m_keep),
    .pass_o  (m_pass),
    .take_o  (m_take)
  );

  irq_level_split #(.W(W)) u_s_lvl (
    .cand_i  (m_pass),
    .deleg_i (s_deleg_i),
    .lvl_en_i(s_lvl_en),
    .keep_o  (s_keep),
    .pass_o  (s_pass),
    .take_o  (s_take)
  );

  always_comb begin
    sel_vec = '0;
    sel_tgt = PRIV_M;
    if (flat_cfg) begin
      sel_vec = cand;
    end else if (m_take) begin
      sel_vec = m_keep;
    end else if (s_take) begin
      sel_vec = s_keep;
      sel_tgt = PRIV_S;
    end else begin
      // anything left in s_pass would need user-level delegation: dropped
      sel_vec = s_pass & '0;
    end
  end

  irq_prio_pick #(.W(W), .CW(CW)) u_pick (
    .vec_i(sel_vec),
    .hit_o(pick_hit),
    .idx_o(pick_idx)
  );

  always_comb begin
    take_o   = pick_hit;
    cause_o  = pick_hit ? pick_idx : '0;
    target_o = pick_hit ? sel_tgt : PRIV_U;
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irq_dispatch_pkg::*;
#(
  parameter int W = 16,
  localparam int CW = $clog2(W)
) (
  input logic [W-1:0]      irq_pend_i,
  input logic [W-1:0]      irq_en_i,
  input logic [PRIV_W-1:0] cur_priv_i,
  input logic              m_gie_i,
  input logic              sup_present_i,
  input logic              usr_present_i,
  input logic              take_o,
  input logic [CW-1:0]     cause_o,
  input logic [PRIV_W-1:0] target_o
);
  logic [W-1:0] cand_c;
  logic         flat_c;

  always_comb begin
    cand_c = irq_pend_i & irq_en_i;
    flat_c = !sup_present_i || !usr_present_i;

    if (cand_c == '0)
      a_r2_no_candidate: assert (!take_o);
    if (take_o)
      a_r1_winner_is_candidate: assert (cand_c[cause_o]);
    if (take_o)
      a_r10_legal_position: assert (rank_of(int'(cause_o)) != RANK_W'(RANK_NONE));
    if (take_o && flat_c)
      a_r7_flat_targets_machine: assert (target_o == PRIV_M);
    if (take_o && (target_o == PRIV_S))
      a_r5_no_sup_from_machine: assert (cur_priv_i != PRIV_M);
    if (take_o && !flat_c && (cur_priv_i == PRIV_M) && !m_gie_i)
      a_r4_machine_gated: assert (target_o != PRIV_M);
    if (!take_o)
      a_r11_idle_zero: assert ((cause_o == '0) && (target_o == PRIV_U));
  end
endmodule

bind irq_dispatch irq_dispatch_chk #(.W(W)) u_chk (
  .irq_pend_i   (irq_pend_i),
  .irq_en_i     (irq_en_i),
  .cur_priv_i   (cur_priv_i),
  .m_gie_i      (m_gie_i),
  .sup_present_i(sup_present_i),
  .usr_present_i(usr_present_i),
  .take_o       (take_o),
  .cause_o      (cause_o),
  .target_o     (target_o)
);

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;
  localparam int W  = 16;
  localparam int CW = $clog2(W);

  logic clk;
  logic rst_n;
  logic [W-1:0]  pend, en, mdl, sdl;
  logic [1:0]    priv;
  logic          mg, sg, sp, up;
  logic          take;
  logic [CW-1:0] cause;
  logic [1:0]    tgt;

  int checks = 0;
  int errors = 0;
  logic [31:0] rs = 32'h1234_5678;

  irq_dispatch #(.W(W)) u_irq_dispatch (
    .irq_pend_i(pend), .irq_en_i(en), .m_deleg_i(mdl), .s_deleg_i(sdl),
    .cur_priv_i(priv), .m_gie_i(mg), .s_gie_i(sg),
    .sup_present_i(sp), .usr_present_i(up),
    .take_o(take), .cause_o(cause), .target_o(tgt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // independent model: first ranked position found in a set
  function automatic int first_of(input logic [W-1:0] v);
    int order [9] = '{11, 3, 7, 9, 1, 5, 8, 0, 4};
    for (int k = 0; k < 9; k++) if (v[order[k]]) return order[k];
    return -1;
  endfunction

  task automatic model(output bit et, output int ec, output int eg);
    logic [W-1:0] c = pend & en;
    logic [W-1:0] mk = c & ~mdl;
    logic [W-1:0] dn = c & mdl;
    logic [W-1:0] sk = dn & ~sdl;
    bit men = (priv != 2'b11) || mg;
    bit sen = sp && ((priv == 2'b00) || (priv == 2'b01 && sg));
    int w = -1;
    int g = 0;
    if (!sp || !up) begin w = first_of(c); g = 3; end
    else if (men && mk != 0) begin w = first_of(mk); g = 3; end
    else if (sen && sk != 0) begin w = first_of(sk); g = 1; end
    et = (w >= 0);
    ec = et ? w : 0;
    eg = et ? g : 0;
  endtask

  task automatic chk(input string req, input bit et, input int ec, input int eg);
    #2;
    checks++;
    if (take !== et || int'(cause) != ec || int'(tgt) != eg) begin
      errors++;
      $display("FAIL %s actual take=%0d cause=%0d tgt=%0d expected take=%0d cause=%0d tgt=%0d",
               req, take, cause, tgt, et, ec, eg);
    end
    #3;
  endtask

  task automatic setv(input logic [W-1:0] p, input logic [W-1:0] e,
                      input logic [W-1:0] m, input logic [W-1:0] s,
                      input logic [1:0] pr, input logic g1, input logic g2,
                      input logic p1, input logic p2);
    pend = p; en = e; mdl = m; sdl = s; priv = pr;
    mg = g1; sg = g2; sp = p1; up = p2;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    setv('0, '0, '0, '0, 2'b11, 0, 0, 1, 1);
    #10 rst_n = 1'b1;
    chk("R11 R2 idle", 0, 0, 0);

    // R1: rank among machine bits, all kept at machine
    setv(16'h0888, 16'h0888, '0, '0, 2'b00, 0, 0, 1, 1);
    chk("R1", 1, 11, 3);
    setv(16'h0088, 16'h0FFF, '0, '0, 2'b00, 0, 0, 1, 1);
    chk("R1 R8", 1, 3, 3);
    // R2: pending but nothing enabled
    setv(16'hFFFF, 16'h0000, '0, '0, 2'b00, 1, 1, 1, 1);
    chk("R2", 0, 0, 0);
    // R3: undelegated bit 1 stays at machine even though bit 11 is more urgent
    setv(16'h0802, 16'h0802, 16'h0800, '0, 2'b00, 0, 0, 1, 1);
    chk("R3", 1, 1, 3);
    // R6: both handed down, supervisor takes the higher rank
    setv(16'h0802, 16'h0802, 16'h0FFF, '0, 2'b00, 0, 0, 1, 1);
    chk("R6", 1, 11, 1);
    // R4: machine mode gating
    setv(16'h0080, 16'h0080, '0, '0, 2'b11, 0, 0, 1, 1);
    chk("R4 gated", 0, 0, 0);
    setv(16'h0080, 16'h0080, '0, '0, 2'b11, 1, 0, 1, 1);
    chk("R4 enabled", 1, 7, 3);
    setv(16'h0080, 16'h0080, '0, '0, 2'b01, 0, 0, 1, 1);
    chk("R4 lower priv", 1, 7, 3);
    // R5: supervisor gating
    setv(16'h0020, 16'h0020, 16'hFFFF, '0, 2'b11, 1, 1, 1, 1);
    chk("R5 in machine", 0, 0, 0);
    setv(16'h0020, 16'h0020, 16'hFFFF, '0, 2'b01, 1, 0, 1, 1);
    chk("R5 sie clear", 0, 0, 0);
    setv(16'h0020, 16'h0020, 16'hFFFF, '0, 2'b01, 0, 1, 1, 1);
    chk("R5 sie set", 1, 5, 1);
    // R9: handed below supervisor is dropped
    setv(16'h0200, 16'h0200, 16'hFFFF, 16'hFFFF, 2'b00, 1, 1, 1, 1);
    chk("R9", 0, 0, 0);
    // R7: flat configurations
    setv(16'h0120, 16'h0120, 16'hFFFF, 16'hFFFF, 2'b11, 0, 0, 1, 0);
    chk("R7 no user", 1, 5, 3);
    setv(16'h0120, 16'h0130, 16'hFFFF, 16'hFFFF, 2'b11, 0, 0, 0, 1);
    chk("R7 no sup", 1, 5, 3);
    // R10: reserved and upper positions
    setv(16'hF444, 16'hFFFF, '0, '0, 2'b00, 1, 1, 1, 1);
    chk("R10 none", 0, 0, 0);
    setv(16'hF445, 16'hFFFF, '0, '0, 2'b00, 1, 1, 1, 1);
    chk("R10 R8 user bit", 1, 0, 3);

    // near-exhaustive sweep over privilege, enables and presence
    for (int pi = 0; pi < 3; pi++) begin
      for (int gx = 0; gx < 4; gx++) begin
        for (int px = 0; px < 4; px++) begin
          for (int n = 0; n < 150; n++) begin
            bit et; int ec; int eg;
            logic [W-1:0] a, b, c, d, e;
            rs = nxt(rs); a = rs[W-1:0];
            rs = nxt(rs); b = rs[W-1:0];
            rs = nxt(rs); c = rs[W-1:0];
            rs = nxt(rs); d = rs[W-1:0];
            rs = nxt(rs); e = rs[W-1:0];
            setv(a, b & e, c, d, (pi == 2) ? 2'b11 : 2'(pi),
                 gx[0], gx[1], px[0], px[1]);
            model(et, ec, eg);
            chk("R1 R4 R5 R6 R7 R8 R9 sweep", et, ec, eg);
          end
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule